// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one conditional-branch instruction per transfer. It takes a 32-bit instruction word, the address of that instruction, the 32-bit condition register and the current loop-count register. From these it decides whether the branch is taken and forms the next instruction address. It also produces the new count value and the new link value, each with its own write enable, and passes out the static prediction-hint bit for use by a front end.

The decision logic is purely combinational. Its results are captured into one output register stage that sits behind a valid/ready handshake, so a downstream stage can stall the unit. An instruction word that is not a conditional branch is still accepted. For such a word the unit flags it as not a branch and requests no register writes.

Top module: `cond_branch_unit`

## Requirements
- R1: Instruction bits are numbered from the MSB as bit 0. Bits 0-5 must equal 16 (instr[31:26] == 6'd16) for the word to count as a branch. The other fields are: option field BO = instr[25:21], condition index BI = instr[20:16], displacement BD = instr[15:2], absolute flag AA = instr[1] and link flag LK = instr[0].
- R2: The displacement is BD shifted left by two and sign-extended to 32 bits. This covers byte offsets from -32768 (BD = 14'h2000) to +32764 (BD = 14'h1FFF).
- R3: With AA = 0 the target is the instruction address plus the displacement. With AA = 1 the target is the displacement alone.
- R4: When instr[23] is 0, the count is decremented by one modulo 2^32. In that case ctr_out carries the new value and ctr_we is 1. When instr[23] is 1, ctr_we is 0.
- R5: When instr[23] is 1, the count check passes. Otherwise the check is evaluated on the decremented value: with instr[22] = 0 it passes when that value is non-zero, and with instr[22] = 1 it passes when that value is zero.
- R6: When instr[25] is 1, the condition check passes. Otherwise it passes when condition-register bit BI, counted from the MSB (cr[31-BI]), equals instr[24].
- R7: taken is 1 only when both checks pass, and next_pc is then the target. Otherwise next_pc is the instruction address plus 4.
- R8: When LK is 1, lr_we is 1 and lr_out is the instruction address plus 4, whether or not the branch is taken.
- R9: hint equals instr[21] for a branch. It has no influence on taken, next_pc, or the count and link outputs.
- R10: For a word whose opcode is not 16, the unit sets not_branch to 1 and sets taken, ctr_we, lr_we and hint to 0. next_pc is the instruction address plus 4.
- R11: An input is accepted when in_valid and in_ready are both 1, and its results appear on the outputs one clock later with out_valid = 1. in_ready is 1 exactly when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, all outputs hold their values.
- R12: A synchronous active-high reset clears out_valid and every result output to zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transfer request |
| in_ready | output | 1 | Unit can accept an input this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| cr | input | 32 | Condition register |
| ctr_in | input | 32 | Current count register |
| out_valid | output | 1 | Result registers hold a result |
| out_ready | input | 1 | Downstream takes the result |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next instruction address |
| ctr_we | output | 1 | Count register write enable |
| ctr_out | output | 32 | New count value |
| lr_we | output | 1 | Link register write enable |
| lr_out | output | 32 | New link value |
| hint | output | 1 | Static prediction hint |
| not_branch | output | 1 | Input word is not a conditional branch |

## Verification
The hardest cases to reach are the count-test edges. A count of exactly 1 must become zero after the decrement, and a count of 0 must wrap to all ones. In both cases the decision must be taken on the post-decrement value, not the original one. The bench reaches these edges by feeding explicit count values of 2, 1 and 0 under both count-test polarities. It holds the condition check open with instr[25] set so that only the count decides the outcome. A back-pressure case keeps out_ready low while a second instruction waits at the input. This shows that the held result neither changes nor gets overwritten.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [31:0] cr,
  input  logic [31:0] ctr_in,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        taken,
  output logic [31:0] next_pc,
  output logic        ctr_we,
  output logic [31:0] ctr_out,
  output logic        lr_we,
  output logic [31:0] lr_out,
  output logic        hint,
  output logic        not_branch
);
  localparam logic [5:0] OPC_BC = 6'd16;

  logic [4:0]  bo, bi;
  logic [13:0] bd;
  logic        aa, lk, is_br;
  logic [31:0] disp, seq_pc, tgt_pc, ctr_next;
  logic        ctr_ok, cond_ok, take, accept;

  assign is_br  = instr[31:26] == OPC_BC;
  assign bo     = instr[25:21];
  assign bi     = instr[20:16];
  assign bd     = instr[15:2];
  assign aa     = instr[1];
  assign lk     = instr[0];

  assign disp     = {{16{bd[13]}}, bd, 2'b00};
  assign seq_pc   = pc + 32'd4;
  assign tgt_pc   = aa ? disp : pc + disp;
  assign ctr_next = bo[2] ? ctr_in : ctr_in - 32'd1;
  assign ctr_ok   = bo[2] | ((ctr_next != 32'd0) ^ bo[1]);
  assign cond_ok  = bo[4] | (cr[5'd31 - bi] == bo[3]);
  assign take     = is_br & ctr_ok & cond_ok;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      next_pc    <= '0;
      ctr_we     <= 1'b0;
      ctr_out    <= '0;
      lr_we      <= 1'b0;
      lr_out     <= '0;
      hint       <= 1'b0;
      not_branch <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      taken      <= take;
      next_pc    <= take ? tgt_pc : seq_pc;
      ctr_we     <= is_br & ~bo[2];
      ctr_out    <= is_br ? ctr_next : ctr_in;
      lr_we      <= is_br & lk;
      lr_out     <= seq_pc;
      hint       <= is_br & bo[0];
      not_branch <= ~is_br;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

module cond_branch_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        is_br,
  input logic        dec,
  input logic        lk,
  input logic [31:0] pc,
  input logic [31:0] ctr_in,
  input logic        out_valid,
  input logic        out_ready,
  input logic        taken,
  input logic [31:0] next_pc,
  input logic        ctr_we,
  input logic [31:0] ctr_out,
  input logic        lr_we,
  input logic [31:0] lr_out,
  input logic        not_branch
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !out_valid && next_pc == 32'd0 && !ctr_we && !lr_we && !taken); // R12
  AST_NB_QUIET: assert property (@(posedge clk) disable iff (rst) out_valid && not_branch |-> !taken && !ctr_we && !lr_we); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |=> out_valid && $stable(next_pc) && $stable(taken) && $stable(ctr_out) && $stable(lr_out)); // R11
  AST_LINK_ALWAYS: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready && is_br && lk |=> lr_we && lr_out == $past(pc) + 32'd4); // R8
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready && is_br && dec |=> ctr_we && ctr_out == $past(ctr_in) - 32'd1); // R4
  AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready |=> taken || next_pc == $past(pc) + 32'd4); // R7
endmodule

bind cond_branch_unit cond_branch_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .is_br(instr[31:26] == 6'd16), .dec(~instr[23]), .lk(instr[0]),
  .pc(pc), .ctr_in(ctr_in), .out_valid(out_valid), .out_ready(out_ready),
  .taken(taken), .next_pc(next_pc), .ctr_we(ctr_we), .ctr_out(ctr_out),
  .lr_we(lr_we), .lr_out(lr_out), .not_branch(not_branch)
);

// File: tb/test_cond_branch_unit.sv
`timescale 1ns/1ps
module test_cond_branch_unit;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] instr = '0, pc = '0, cr = '0, ctr_in = '0;
  logic taken, ctr_we, lr_we, hint, not_branch;
  logic [31:0] next_pc, ctr_out, lr_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cond_branch_unit i_cond_branch_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .pc(pc), .cr(cr), .ctr_in(ctr_in),
    .out_valid(out_valid), .out_ready(out_ready), .taken(taken),
    .next_pc(next_pc), .ctr_we(ctr_we), .ctr_out(ctr_out),
    .lr_we(lr_we), .lr_out(lr_out), .hint(hint), .not_branch(not_branch)
  );

  function automatic logic [31:0] mk(input logic [4:0] bo, input logic [4:0] bi,
                                     input logic [13:0] bd, input logic aa, input logic lk);
    return {6'd16, bo, bi, bd, aa, lk};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] c, input logic [31:0] n);
    @(negedge clk);
    instr = i; pc = p; cr = c; ctr_in = n; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 next_pc", next_pc, 32'd0);
    chk("R12 lr_out", lr_out, 32'd0);
    chk("R12 flags", {27'd0, taken, ctr_we, lr_we, hint, not_branch}, 32'd0);
    chk("R11 idle ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_cond;
    issue(mk(5'b01100, 5'd2, 14'd4, 1'b0, 1'b0), 32'h1000, 32'h2000_0000, 32'd7);
    chk("R6 true bit taken", {31'd0, taken}, 32'd1);
    chk("R3 relative target", next_pc, 32'h1010);
    chk("R4 no dec", {31'd0, ctr_we}, 32'd0);
    chk("R11 out_valid", {31'd0, out_valid}, 32'd1);
    issue(mk(5'b01100, 5'd2, 14'd4, 1'b0, 1'b0), 32'h1000, 32'hDFFF_FFFF, 32'd7);
    chk("R7 not taken", {31'd0, taken}, 32'd0);
    chk("R7 fallthrough", next_pc, 32'h1004);
    issue(mk(5'b00100, 5'd31, 14'd8, 1'b0, 1'b0), 32'h2000, 32'hFFFF_FFFE, 32'd0);
    chk("R6 false polarity", {31'd0, taken}, 32'd1);
    chk("R6 target", next_pc, 32'h2020);
  endtask

  task automatic t_count;
    issue(mk(5'b10000, 5'd0, 14'h3FFF, 1'b0, 1'b0), 32'h100, 32'd0, 32'd2);
    chk("R5 nz taken", {31'd0, taken}, 32'd1);
    chk("R4 dec value", ctr_out, 32'd1);
    chk("R4 dec we", {31'd0, ctr_we}, 32'd1);
    chk("R2 back one word", next_pc, 32'hFC);
    issue(mk(5'b10000, 5'd0, 14'h3FFF, 1'b0, 1'b0), 32'h100, 32'd0, 32'd1);
    chk("R5 post-dec zero", {31'd0, taken}, 32'd0);
    chk("R4 dec to zero", ctr_out, 32'd0);
    issue(mk(5'b10010, 5'd0, 14'd1, 1'b0, 1'b0), 32'h100, 32'd0, 32'd1);
    chk("R5 branch on zero", {31'd0, taken}, 32'd1);
    issue(mk(5'b10010, 5'd0, 14'd1, 1'b0, 1'b0), 32'h100, 32'd0, 32'd0);
    chk("R5 wrap not zero", {31'd0, taken}, 32'd0);
    chk("R4 wrap value", ctr_out, 32'hFFFF_FFFF);
    issue(mk(5'b00000, 5'd0, 14'd2, 1'b0, 1'b0), 32'h40, 32'h0, 32'd5);
    chk("R1 combined tests", {31'd0, taken}, 32'd1);
    chk("R1 combined ctr", ctr_out, 32'd4);
  endtask

  task automatic t_disp;
    issue(mk(5'b10100, 5'd0, 14'h2000, 1'b0, 1'b0), 32'h0001_0000, 32'd0, 32'd0);
    chk("R2 min offset", next_pc, 32'h0000_8000);
    issue(mk(5'b10100, 5'd0, 14'h1FFF, 1'b0, 1'b0), 32'h0001_0000, 32'd0, 32'd0);
    chk("R2 max offset", next_pc, 32'h0001_7FFC);
    issue(mk(5'b10100, 5'd0, 14'h3FFF, 1'b1, 1'b0), 32'h5000, 32'd0, 32'd0);
    chk("R3 absolute", next_pc, 32'hFFFF_FFFC);
  endtask

  task automatic t_link;
    issue(mk(5'b01100, 5'd0, 14'd4, 1'b0, 1'b1), 32'h3000, 32'd0, 32'd0);
    chk("R8 nt taken", {31'd0, taken}, 32'd0);
    chk("R8 lr_we", {31'd0, lr_we}, 32'd1);
    chk("R8 lr value", lr_out, 32'h3004);
    issue(mk(5'b10100, 5'd0, 14'd4, 1'b0, 1'b0), 32'h3000, 32'd0, 32'd0);
    chk("R8 no link", {31'd0, lr_we}, 32'd0);
  endtask

  task automatic t_hint;
    issue(mk(5'b10101, 5'd0, 14'd3, 1'b0, 1'b0), 32'h600, 32'd0, 32'd9);
    chk("R9 hint set", {31'd0, hint}, 32'd1);
    chk("R9 taken", {31'd0, taken}, 32'd1);
    chk("R9 target", next_pc, 32'h60C);
    issue(mk(5'b10100, 5'd0, 14'd3, 1'b0, 1'b0), 32'h600, 32'd0, 32'd9);
    chk("R9 hint clear", {31'd0, hint}, 32'd0);
    chk("R9 same target", next_pc, 32'h60C);
  endtask

  task automatic t_nonbranch;
    issue({6'd31, 5'b00000, 5'd0, 14'd4, 1'b0, 1'b1}, 32'h700, 32'd0, 32'd3);
    chk("R10 flag", {31'd0, not_branch}, 32'd1);
    chk("R10 quiet", {29'd0, taken, ctr_we, lr_we}, 32'd0);
    chk("R10 hint", {31'd0, hint}, 32'd0);
    chk("R10 next", next_pc, 32'h704);
  endtask

  task automatic t_stall;
    @(negedge clk);
    instr = mk(5'b10100, 5'd0, 14'd16, 1'b0, 1'b0); pc = 32'h800;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    instr = mk(5'b10100, 5'd0, 14'd32, 1'b0, 1'b0); pc = 32'h900;
    chk("R11 busy ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R11 held", next_pc, 32'h840);
    chk("R11 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second result", next_pc, 32'h980);
    @(negedge clk);
    chk("R11 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cond();
    t_count();
    t_disp();
    t_link();
    t_hint();
    t_nonbranch();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule